// File: doc/BRIEF.md
# Mixed-Format Registered Multiplier

This block multiplies two 16-bit operands and keeps the 32-bit product as two 16-bit halves, a high half and a low half, each in its own register. Every operand carries its own format bit, so each one is read either as two's complement or as an unsigned magnitude, and any pairing of the two formats is legal. Two optional steps act on the product before it is split. The first, format adjust, drops the redundant sign bit and copies the sign into the low half. The second, rounding, adds one at the top bit of the low half, which rounds the high half.

All registers run on one clock and load only when their own enable is high: the X operand, the Y operand, the high half and the low half. The round request is captured together with the X operand. A bypass control makes both product registers transparent. A select input chooses which half appears on the shared product port. The low half also goes to a write-back port aimed at the bidirectional Y bus. Each tri-state port is represented by a data output and a drive-enable output. The product registers must be loaded before the next operands are loaded.

Top module: `mixed_mult`

## Requirements
- R1: After the active-low reset, every register holds zero, so both the product port and the write-back port show 0 while bypass is low.
- R2: When its format bit is 1, an operand is read as two's complement (sign-extended). When the bit is 0, it is read as unsigned (zero-extended). The format bit is captured with its operand, and each operand has its own bit.
- R3: With adjust and round off, the 32-bit result is the operand product modulo 2^32. The high half holds bits 31:16 and the low half holds bits 15:0.
- R4: With fmt_adj high, the result is the raw 32-bit product shifted left by one, with bit 0 set to bit 31 of the raw product.
- R5: When rnd_in is captured as 1, 0x8000 is added to the result modulo 2^32, after any format adjustment. rnd_in is captured only when x_ld is high.
- R6: The operand and product registers change only in a cycle where their own load enable is high. Otherwise they hold their value, and each product half loads independently.
- R7: With bypass high, the product port and the write-back port show the result of the current operand registers without any product register load.
- R8: When hi_sel is 1, prod_out shows the high half. When hi_sel is 0, it shows the low half, which equals y_back_out.
- R9: prod_drv_en follows prod_oe, and y_back_en follows yback_oe. Neither enable changes the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_in | input | 16 | X operand |
| x_signed | input | 1 | X format: 1 two's complement, 0 unsigned |
| x_ld | input | 1 | X register load enable (also captures rnd_in) |
| y_in | input | 16 | Y operand (input side of Y bus) |
| y_signed | input | 1 | Y format: 1 two's complement, 0 unsigned |
| y_ld | input | 1 | Y register load enable |
| rnd_in | input | 1 | Round request |
| fmt_adj | input | 1 | Format adjust enable |
| msp_ld | input | 1 | High-half register load enable |
| lsp_ld | input | 1 | Low-half register load enable |
| bypass | input | 1 | Make product registers transparent |
| hi_sel | input | 1 | Product port select: 1 high half, 0 low half |
| prod_oe | input | 1 | Product port drive request |
| yback_oe | input | 1 | Write-back drive request |
| prod_out | output | 16 | Product port data |
| prod_drv_en | output | 1 | Product port drive enable |
| y_back_out | output | 16 | Low half for the Y bus |
| y_back_en | output | 1 | Y bus drive enable |

## Verification
The hardest case to reach is a split state in which the two product halves come from different operand sets. This state arises only when the operand and half-register load enables are pulsed in separate cycles. The stimulus loads one product completely and then loads new operands with only the high-half enable. It then checks that the high half shows the new result and the low half still shows the old one. A separate scenario changes rnd_in between the operand load and the product load, which shows that the round request is taken with X and is not sampled live.

// File: rtl/mixed_mult.sv
module mixed_mult #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x_in,
  input  logic         x_signed,
  input  logic         x_ld,
  input  logic [W-1:0] y_in,
  input  logic         y_signed,
  input  logic         y_ld,
  input  logic         rnd_in,
  input  logic         fmt_adj,
  input  logic         msp_ld,
  input  logic         lsp_ld,
  input  logic         bypass,
  input  logic         hi_sel,
  input  logic         prod_oe,
  input  logic         yback_oe,
  output logic [W-1:0] prod_out,
  output logic         prod_drv_en,
  output logic [W-1:0] y_back_out,
  output logic         y_back_en
);
  localparam int EW = W + 1;
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] RND_ONE = PW'(1) << (W - 1);

  logic [W-1:0] xr, yr, msp_q, lsp_q;
  logic         xs_r, ys_r, rnd_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xr <= '0; yr <= '0; xs_r <= 1'b0; ys_r <= 1'b0; rnd_r <= 1'b0;
      msp_q <= '0; lsp_q <= '0;
    end else begin
      if (x_ld) begin
        xr <= x_in; xs_r <= x_signed; rnd_r <= rnd_in;
      end
      if (y_ld) begin
        yr <= y_in; ys_r <= y_signed;
      end
      if (msp_ld) msp_q <= res[PW-1:W];
      if (lsp_ld) lsp_q <= res[W-1:0];
    end
  end

  logic signed [EW-1:0]   xe, ye;
  logic signed [2*EW-1:0] pfull;
  logic [PW-1:0]          raw, adj, res;

  assign xe    = $signed({xs_r & xr[W-1], xr});
  assign ye    = $signed({ys_r & yr[W-1], yr});
  assign pfull = xe * ye;
  assign raw   = pfull[PW-1:0];
  assign adj   = fmt_adj ? {raw[PW-2:0], raw[PW-1]} : raw;
  assign res   = rnd_r ? adj + RND_ONE : adj;

  logic [W-1:0] msp_v, lsp_v;
  assign msp_v = bypass ? res[PW-1:W] : msp_q;
  assign lsp_v = bypass ? res[W-1:0]  : lsp_q;

  assign prod_out    = hi_sel ? msp_v : lsp_v;
  assign prod_drv_en = prod_oe;
  assign y_back_out  = lsp_v;
  assign y_back_en   = yback_oe;
endmodule

module mixed_mult_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bypass,
  input logic         hi_sel,
  input logic         msp_ld,
  input logic         lsp_ld,
  input logic         fmt_adj,
  input logic         rnd_r,
  input logic [W-1:0] xr,
  input logic [W-1:0] yr,
  input logic [W-1:0] prod_out,
  input logic [W-1:0] y_back_out
);
  AST_MSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !msp_ld && hi_sel) |=> (bypass || !hi_sel || $stable(prod_out))); // R6

  AST_LSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !lsp_ld) |=> (bypass || $stable(y_back_out))); // R6

  AST_LOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_sel |-> (prod_out == y_back_out)); // R8

  AST_ZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !fmt_adj && !rnd_r && (xr == '0 || yr == '0)) |-> (prod_out == '0)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !bypass) |-> (prod_out == '0 && y_back_out == '0)); // R1
endmodule

bind mixed_mult mixed_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .hi_sel(hi_sel),
  .msp_ld(msp_ld), .lsp_ld(lsp_ld), .fmt_adj(fmt_adj), .rnd_r(rnd_r),
  .xr(xr), .yr(yr), .prod_out(prod_out), .y_back_out(y_back_out)
);

// File: tb/mixed_mult_tb.sv
module mixed_mult_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] x_in = '0, y_in = '0;
  logic x_signed = 0, y_signed = 0, x_ld = 0, y_ld = 0, rnd_in = 0, fmt_adj = 0;
  logic msp_ld = 0, lsp_ld = 0, bypass = 0, hi_sel = 0, prod_oe = 0, yback_oe = 0;
  logic [15:0] prod_out, y_back_out;
  logic prod_drv_en, y_back_en;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mixed_mult u_dut (.*);

  function automatic logic [31:0] ref_res(logic [15:0] x, logic xs, logic [15:0] y,
                                          logic ys, logic fa, logic rnd);
    longint a, b, p;
    logic [31:0] r;
    a = xs ? longint'($signed(x)) : longint'(x);
    b = ys ? longint'($signed(y)) : longint'(y);
    p = a * b;
    r = p[31:0];
    if (fa) r = {r[30:0], r[31]};
    if (rnd) r = r + 32'h8000;
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_ops(logic [15:0] x, logic xs, logic [15:0] y, logic ys, logic rnd);
    @(negedge clk);
    x_in = x; x_signed = xs; y_in = y; y_signed = ys; rnd_in = rnd; x_ld = 1; y_ld = 1;
    @(negedge clk);
    x_ld = 0; y_ld = 0;
  endtask

  task automatic load_prod(logic m, logic l);
    msp_ld = m; lsp_ld = l;
    @(negedge clk);
    msp_ld = 0; lsp_ld = 0;
    #1;
  endtask

  task automatic check_halves(string req, logic [31:0] e);
    hi_sel = 1; #1; check(req, prod_out, e[31:16]);
    hi_sel = 0; #1; check(req, prod_out, e[15:0]);
    check(req, y_back_out, e[15:0]);
  endtask

  task automatic t_mult(string req, logic [15:0] x, logic xs, logic [15:0] y,
                        logic ys, logic fa, logic rnd);
    fmt_adj = fa;
    load_ops(x, xs, y, ys, rnd);
    load_prod(1, 1);
    check_halves(req, ref_res(x, xs, y, ys, fa, rnd));
    fmt_adj = 0;
  endtask

  task automatic t_reset;
    #1; hi_sel = 1; #1; check("R1", prod_out, 16'h0);
    hi_sel = 0; #1; check("R1", y_back_out, 16'h0);
  endtask

  task automatic t_split;
    logic [31:0] a, b;
    a = ref_res(16'h1234, 0, 16'h5678, 0, 0, 0);
    b = ref_res(16'h00FF, 0, 16'h0101, 0, 0, 0);
    load_ops(16'h1234, 0, 16'h5678, 0, 0);
    load_prod(1, 1);
    load_ops(16'h00FF, 0, 16'h0101, 0, 0);
    #1; check_halves("R6", a);
    load_prod(1, 0);
    hi_sel = 1; #1; check("R6", prod_out, b[31:16]);
    hi_sel = 0; #1; check("R6", prod_out, a[15:0]);
  endtask

  task automatic t_rnd_capture;
    load_ops(16'h0123, 0, 16'h4567, 0, 1);
    rnd_in = 0;
    load_prod(1, 1);
    check_halves("R5", ref_res(16'h0123, 0, 16'h4567, 0, 0, 1));
  endtask

  task automatic t_bypass;
    bypass = 1;
    load_ops(16'hFFFE, 1, 16'h0007, 0, 0);
    #1; check_halves("R7", ref_res(16'hFFFE, 1, 16'h0007, 0, 0, 0));
    bypass = 0; #1;
  endtask

  task automatic t_enables;
    logic [15:0] d;
    hi_sel = 1; #1; d = prod_out;
    prod_oe = 1; yback_oe = 0; #1;
    checks++; if (prod_drv_en !== 1'b1 || y_back_en !== 1'b0) begin
      errors++; $display("FAIL R9 actual=%b%b expected=10", prod_drv_en, y_back_en); end
    check("R9", prod_out, d);
    prod_oe = 0; yback_oe = 1; #1;
    checks++; if (prod_drv_en !== 1'b0 || y_back_en !== 1'b1) begin
      errors++; $display("FAIL R9 actual=%b%b expected=01", prod_drv_en, y_back_en); end
    yback_oe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mult("R3", 16'h1234, 0, 16'h5678, 0, 0, 0);
    t_mult("R3", 16'hFFFF, 0, 16'hFFFF, 0, 0, 0);
    t_mult("R2", 16'hFFFF, 1, 16'hFFFF, 1, 0, 0);
    t_mult("R2", 16'h8000, 1, 16'h8000, 1, 0, 0);
    t_mult("R2", 16'hFFFF, 1, 16'hFFFF, 0, 0, 0);
    t_mult("R2", 16'hFFFF, 0, 16'h8001, 1, 0, 0);
    t_mult("R4", 16'hFFFD, 1, 16'h0005, 1, 1, 0);
    t_mult("R4", 16'h4000, 1, 16'h3000, 1, 1, 0);
    t_mult("R5", 16'h0123, 0, 16'h4567, 0, 0, 1);
    t_mult("R5", 16'hFFFF, 0, 16'hFFFF, 0, 0, 1);
    t_mult("R5", 16'h9ABC, 1, 16'h1357, 1, 1, 1);
    t_rnd_capture();
    t_split();
    t_bypass();
    t_enables();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule